// File: doc/BRIEF.md
# Multi-Target SMBus Slave Front End

This block is the serial front end of a combined thermal-monitor and configuration-memory device. It samples the two bus wires with the system clock, finds START and STOP conditions, and decodes the address byte. Three 4-bit preambles steer each transfer to one of three back ends: a 16-bit temperature register file, an EEPROM controller, or the write-protection flag logic. The block drives SDA low for acknowledges and for zero bits of read data. It holds the temperature register pointer. It also aborts a transfer when SCL stays low too long.

The back ends stay outside the block. The temperature file sees `ts_ptr`, returns `ts_rdata` and takes `ts_we`/`ts_wdata`. The EEPROM controller receives byte strobes, returns `ee_rdata` and is told when to advance. It reports `ee_busy` while a write is in progress. The flag logic reports whether its flag is set and takes a command strobe.

The sequencer has eight states.
- `ST_IDLE` ignores the bus until a START.
- `ST_ADDR` shifts in the address byte. `ST_ADDR_END` waits for the falling edge after bit 8. On that edge it goes to `ST_ACK` if the address matches, or back to `ST_IDLE` if it does not.
- `ST_ACK` holds the ninth clock. On its falling edge it goes to `ST_TX` for a read, to `ST_RX` for a write, or to `ST_IDLE` for a flag read.
- `ST_RX` shifts in a data byte. `ST_RX_END` then decides ACK or NACK and returns to `ST_ACK`.
- `ST_TX` shifts out a byte and then enters `ST_TX_ACK`. There, a master ACK returns to `ST_TX` with the next byte, and a NACK goes to `ST_IDLE`.
- From any state, START goes to `ST_ADDR`. STOP or a timeout goes to `ST_IDLE`.

Top module: `smb_slave_front`

## Requirements
- R1: After reset `sda_oe` is 0, `ts_ptr` is 0 and no strobe output is high.
- R2: The address byte is read MSB first. Bits [7:4] select the target: 4'b0011 selects temperature, 4'b1010 selects EEPROM and 4'b0110 selects flags. Bits [3:1] must equal `strap`, and bit 0 is 1 for a read. Any other address is not acknowledged, and the block drives nothing and raises no strobe until the next START.
- R3: A matching address, and every accepted written byte, is acknowledged by `sda_oe`=1. The drive lasts from the SCL fall after the 8th bit to the SCL fall after the 9th.
- R4: A temperature write has three bytes: the pointer byte, which loads `ts_ptr` from its low PTR_W bits, then the MSB, then the LSB. After the LSB, `ts_we` pulses once with `ts_wdata`={MSB,LSB}. Any later byte is not acknowledged.
- R5: A temperature read returns `ts_rdata[15:8]` and then `ts_rdata[7:0]`, addressed by `ts_ptr`. The pointer persists across transfers. A write that carries only the pointer byte, followed by a repeated START and a read, reads from the new pointer without pulsing `ts_we`.
- R6: In an EEPROM write, the first byte after the address pulses `ee_addr_we` and each later byte pulses `ee_data_we`, with the byte on `ee_byte`. A STOP after a START pulses `bus_stop`. While `ee_busy`=1, an EEPROM address is not acknowledged.
- R7: An EEPROM read sends `ee_rdata` MSB first and pulses `ee_rd_adv` after each byte. Reading continues while the master acknowledges. After a master NACK the block drives nothing.
- R8: A flag read transfers no data. The address is acknowledged when `pf_set`=0 and not acknowledged when `pf_set`=1.
- R9: A flag write acknowledges a dummy address byte and a dummy data byte. `pf_wr` pulses once after the data byte, and a further byte is not acknowledged.
- R10: Between START and STOP, if SCL stays low for TMO_CYC clock cycles, SDA is released and the block returns to idle. The count restarts on every SCL falling edge, so a transfer that is clocked normally never times out, however long it lasts.
- R11: A START in the middle of a byte aborts the transfer and restarts address reception.
- R12: `sda_oe` rises only while SCL is low. Data changes after an SCL fall and is sampled on an SCL rise.
- R13: At most one of `ts_we`, `ee_addr_we`, `ee_data_we`, `pf_wr` and `ee_rd_adv` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Device select strap pins |
| ts_ptr | output | PTR_W | Temperature register pointer |
| ts_rdata | input | 16 | Temperature register at `ts_ptr` |
| ts_we | output | 1 | Temperature register write strobe |
| ts_wdata | output | 16 | Temperature write value |
| ee_busy | input | 1 | EEPROM internal write in progress |
| ee_addr_we | output | 1 | EEPROM address byte strobe |
| ee_data_we | output | 1 | EEPROM data byte strobe |
| ee_byte | output | 8 | Last received byte |
| ee_rdata | input | 8 | EEPROM byte at the current address |
| ee_rd_adv | output | 1 | EEPROM byte sent, advance the address |
| pf_set | input | 1 | Protection flag is set |
| pf_wr | output | 1 | Protection flag write command |
| bus_stop | output | 1 | STOP seen after a START |

## Verification
Most sequencer faults show at the wire within one bit time. A wrong bit count or a lost state shifts the acknowledge off the ninth clock, so the master samples the wrong level in the same byte. A target mix-up sends a strobe to the wrong port, or sends the wrong byte, within the next byte. Pointer and byte-index faults only show when a later read returns the wrong half or the wrong register. The directed scenarios therefore chain writes and reads across repeated STARTs. A timer fault shows as SDA still held after TMO_CYC cycles of low clock, or as an ACK lost during a long transfer that is clocked normally.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ACK,
        ST_RX,
        ST_RX_END,
        ST_TX,
        ST_TX_ACK
    } smb_state_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_TEMP,
        TGT_EE,
        TGT_FLAG
    } smb_tgt_t;

    localparam logic [3:0] PRE_TEMP = 4'b0011;
    localparam logic [3:0] PRE_EE   = 4'b1010;
    localparam logic [3:0] PRE_FLAG = 4'b0110;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic [STAGES-1:0] pipe;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe <= '1;
                    prev <= 1'b1;
                end else begin
                    pipe <= {pipe[STAGES-2:0], din[i]};
                    prev <= pipe[STAGES-1];
                end
            end

            assign dout[i]  = pipe[STAGES-1];
            assign dprev[i] = prev;
        end
    endgenerate

endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
    parameter int unsigned TMO_CYC = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic low,
    input  logic restart,
    output logic expire
);

    localparam int unsigned CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (!armed || restart) begin
                cnt <= '0;
            end else if (low) begin
                if (cnt == CW'(TMO_CYC - 1)) begin
                    expire <= 1'b1;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TMO_CYC));

    // R10
    expire_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(armed));

endmodule

// File: rtl/smb_slave_front.sv
module smb_slave_front
    import smb_pkg::*;
#(
    parameter int unsigned PTR_W       = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TMO_CYC     = 6_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [2:0]       strap,
    output logic [PTR_W-1:0] ts_ptr,
    input  logic [15:0]      ts_rdata,
    output logic             ts_we,
    output logic [15:0]      ts_wdata,
    input  logic             ee_busy,
    output logic             ee_addr_we,
    output logic             ee_data_we,
    output logic [7:0]       ee_byte,
    input  logic [7:0]       ee_rdata,
    output logic             ee_rd_adv,
    input  logic             pf_set,
    output logic             pf_wr,
    output logic             bus_stop
);

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned BIT_CW  = $clog2(BYTE_W);
    localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(BYTE_W - 1);

    // ---------------- input conditioning ----------------
    logic [1:0] line_s, line_p;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    smb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sda_i, scl_i}),
        .dout  (line_s),
        .dprev (line_p)
    );

    assign scl_s    = line_s[0];
    assign sda_s    = line_s[1];
    assign scl_p    = line_p[0];
    assign sda_p    = line_p[1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

    // ---------------- low-clock timeout ----------------
    logic active, tmo;

    smb_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (active),
        .low     (~scl_s),
        .restart (scl_fall | start_ev),
        .expire  (tmo)
    );

    // ---------------- sequencer state ----------------
    smb_state_t        state, state_d;
    smb_tgt_t          tgt, addr_tgt;
    logic [BIT_CW-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg, txsh, msb_q, tx_pick;
    logic [1:0]        idx;
    logic              rw, mack, addr_ok, rx_accept;

    always_comb begin
        if (shreg[3:1] != strap)           addr_tgt = TGT_NONE;
        else if (shreg[7:4] == PRE_TEMP)   addr_tgt = TGT_TEMP;
        else if (shreg[7:4] == PRE_EE)     addr_tgt = TGT_EE;
        else if (shreg[7:4] == PRE_FLAG)   addr_tgt = TGT_FLAG;
        else                               addr_tgt = TGT_NONE;
    end

    assign addr_ok = (addr_tgt != TGT_NONE) && !(addr_tgt == TGT_EE && ee_busy);

    always_comb begin
        unique case (tgt)
            TGT_TEMP: rx_accept = (idx <= 2'd2);
            TGT_EE:   rx_accept = 1'b1;
            TGT_FLAG: rx_accept = (idx <= 2'd1);
            default:  rx_accept = 1'b0;
        endcase
    end

    assign tx_pick = (tgt == TGT_EE) ? ee_rdata :
                     (idx[0] ? ts_rdata[7:0] : ts_rdata[15:8]);

    always_comb begin
        state_d = state;
        if (tmo) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_rise && bitcnt == BIT_LAST) state_d = ST_ADDR_END;
                ST_ADDR_END: if (scl_fall) state_d = addr_ok ? ST_ACK : ST_IDLE;
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!rw)                 state_d = ST_RX;
                        else if (tgt == TGT_FLAG) state_d = ST_IDLE;
                        else                     state_d = ST_TX;
                    end
                end
                ST_RX:       if (scl_rise && bitcnt == BIT_LAST) state_d = ST_RX_END;
                ST_RX_END:   if (scl_fall) state_d = ST_ACK;
                ST_TX:       if (scl_fall && bitcnt == BIT_LAST) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_d = mack ? ST_TX : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe     <= 1'b0;
            active     <= 1'b0;
            bitcnt     <= '0;
            shreg      <= '0;
            txsh       <= '0;
            msb_q      <= '0;
            tgt        <= TGT_NONE;
            rw         <= 1'b0;
            idx        <= '0;
            mack       <= 1'b0;
            ts_ptr     <= '0;
            ts_we      <= 1'b0;
            ts_wdata   <= '0;
            ee_addr_we <= 1'b0;
            ee_data_we <= 1'b0;
            ee_byte    <= '0;
            ee_rd_adv  <= 1'b0;
            pf_wr      <= 1'b0;
            bus_stop   <= 1'b0;
        end else begin
            ts_we      <= 1'b0;
            ee_addr_we <= 1'b0;
            ee_data_we <= 1'b0;
            ee_rd_adv  <= 1'b0;
            pf_wr      <= 1'b0;
            bus_stop   <= 1'b0;
            if (tmo) begin
                active <= 1'b0;
                sda_oe <= 1'b0;
            end else if (start_ev) begin
                active <= 1'b1;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (stop_ev) begin
                bus_stop <= active;
                active   <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_ADDR_END: begin
                        if (scl_fall && addr_ok) begin
                            tgt    <= addr_tgt;
                            rw     <= shreg[0];
                            idx    <= '0;
                            sda_oe <= (addr_tgt == TGT_FLAG && shreg[0]) ? ~pf_set : 1'b1;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw && tgt != TGT_FLAG) begin
                                txsh   <= tx_pick;
                                sda_oe <= ~tx_pick[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RX_END: begin
                        if (scl_fall) begin
                            ee_byte <= shreg;
                            if (rx_accept) begin
                                sda_oe <= 1'b1;
                                unique case (tgt)
                                    TGT_TEMP: begin
                                        if (idx == 2'd0) ts_ptr <= shreg[PTR_W-1:0];
                                        if (idx == 2'd1) msb_q  <= shreg;
                                        if (idx == 2'd2) begin
                                            ts_we    <= 1'b1;
                                            ts_wdata <= {msb_q, shreg};
                                        end
                                    end
                                    TGT_EE: begin
                                        if (idx == 2'd0) ee_addr_we <= 1'b1;
                                        else             ee_data_we <= 1'b1;
                                    end
                                    TGT_FLAG: pf_wr <= (idx == 2'd1);
                                    default: ;
                                endcase
                            end
                            if (idx != 2'd3) idx <= idx + 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == BIT_LAST) begin
                                sda_oe    <= 1'b0;
                                ee_rd_adv <= (tgt == TGT_EE);
                                idx       <= idx + 1'b1;
                            end else begin
                                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txsh[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall && mack) begin
                            txsh   <= tx_pick;
                            sda_oe <= ~tx_pick[BYTE_W-1];
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    // R12
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ts_we, ee_addr_we, ee_data_we, pf_wr, ee_rd_adv}));

    // R10
    tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (state == ST_IDLE && !sda_oe));

    // R11
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !tmo) |=> (state == ST_ADDR && !sda_oe && bitcnt == '0));

    // R4
    ts_we_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we |-> (state == ST_ACK && sda_oe));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_ev) |=> !sda_oe);

endmodule

// File: tb/smb_slave_front_tb.sv
module smb_slave_front_tb;
    localparam int          PTR_W = 3;
    localparam int          TMO   = 300;
    localparam int          Q     = 20;
    localparam logic [2:0]  STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, ts_we, ee_addr_we, ee_data_we, ee_rd_adv, pf_wr, bus_stop;
    logic [PTR_W-1:0] ts_ptr;
    logic [15:0] ts_rdata, ts_wdata;
    logic [7:0]  ee_byte, ee_rdata;
    logic ee_busy = 1'b0, pf_set = 1'b0;
    wire  sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    smb_slave_front #(.PTR_W(PTR_W), .SYNC_STAGES(2), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap(STRAP), .ts_ptr(ts_ptr), .ts_rdata(ts_rdata), .ts_we(ts_we),
        .ts_wdata(ts_wdata), .ee_busy(ee_busy), .ee_addr_we(ee_addr_we),
        .ee_data_we(ee_data_we), .ee_byte(ee_byte), .ee_rdata(ee_rdata),
        .ee_rd_adv(ee_rd_adv), .pf_set(pf_set), .pf_wr(pf_wr), .bus_stop(bus_stop)
    );

    // back-end models
    int n_tswe = 0, n_eea = 0, n_eed = 0, n_rd = 0, n_pf = 0, n_stop = 0;
    int v12 = 0, v13 = 0;
    logic [7:0] last_eea = '0, last_eed = '0;
    logic [15:0] last_tsw = '0;
    logic prev_oe = 1'b0;
    logic [7:0] rd_base = 8'h50;

    assign ts_rdata = {5'b10100, ts_ptr, 5'b01100, ts_ptr};
    assign ee_rdata = rd_base + 8'(n_rd);

    always @(posedge clk) begin
        if (ts_we)      begin n_tswe <= n_tswe + 1; last_tsw <= ts_wdata; end
        if (ee_addr_we) begin n_eea  <= n_eea + 1;  last_eea <= ee_byte;  end
        if (ee_data_we) begin n_eed  <= n_eed + 1;  last_eed <= ee_byte;  end
        if (ee_rd_adv)  n_rd   <= n_rd + 1;
        if (pf_wr)      n_pf   <= n_pf + 1;
        if (bus_stop)   n_stop <= n_stop + 1;
        prev_oe <= sda_oe;
        if (rst_n && sda_oe && !prev_oe && scl_m) v12 <= v12 + 1;
        if (rst_n && $countones({ts_we, ee_addr_we, ee_data_we, pf_wr, ee_rd_adv}) > 1) v13 <= v13 + 1;
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic m_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic m_bit(input logic b, output logic s);
        sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_rbyte(input logic ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin m_bit(1'b1, s); d[i] = s; end
        m_bit(~ack, s);
    endtask

    function automatic logic [7:0] adr(input logic [3:0] pre, input logic rd);
        return {pre, STRAP, rd};
    endfunction

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(ts_ptr == '0, "R1 ts_ptr", ts_ptr, 0);
        chk(n_tswe + n_eea + n_eed + n_rd + n_pf == 0, "R1 strobes", n_tswe + n_eea + n_eed + n_rd + n_pf, 0);
    endtask

    task automatic t_ts_write();
        logic a;
        int w0 = n_tswe;
        m_start();
        m_wbyte(adr(4'b0011, 1'b0), a); chk(a, "R2 temp addr ack", a, 1);
        m_wbyte(8'h05, a);              chk(a, "R3 ptr ack", a, 1);
        chk(sda_oe == 1'b0, "R3 release after 9th", sda_oe, 0);
        m_wbyte(8'hC3, a);              chk(a, "R3 msb ack", a, 1);
        m_wbyte(8'h5A, a);              chk(a, "R3 lsb ack", a, 1);
        chk(n_tswe == w0 + 1, "R4 ts_we count", n_tswe, w0 + 1);
        chk(last_tsw == 16'hC35A, "R4 ts_wdata", last_tsw, 16'hC35A);
        chk(ts_ptr == 3'd5, "R4 ts_ptr", ts_ptr, 5);
        m_wbyte(8'h77, a);              chk(!a, "R4 extra byte nack", a, 0);
        chk(n_tswe == w0 + 1, "R4 no extra write", n_tswe, w0 + 1);
        m_stop();
    endtask

    task automatic t_ts_read();
        logic a; logic [7:0] d;
        m_start();
        m_wbyte(adr(4'b0011, 1'b1), a); chk(a, "R5 read addr ack", a, 1);
        m_rbyte(1'b1, d); chk(d == 8'hA5, "R5 msb", d, 8'hA5);
        m_rbyte(1'b0, d); chk(d == 8'h65, "R5 lsb", d, 8'h65);
        chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
        m_stop();
    endtask

    task automatic t_ts_selective();
        logic a; logic [7:0] d;
        int w0 = n_tswe;
        m_start();
        m_wbyte(adr(4'b0011, 1'b0), a);
        m_wbyte(8'h02, a);
        m_start();
        m_wbyte(adr(4'b0011, 1'b1), a); chk(a, "R5 sel read ack", a, 1);
        m_rbyte(1'b1, d); chk(d == 8'hA2, "R5 sel msb", d, 8'hA2);
        m_rbyte(1'b0, d); chk(d == 8'h62, "R5 sel lsb", d, 8'h62);
        m_stop();
        chk(n_tswe == w0, "R5 pointer-only write", n_tswe, w0);
    endtask

    task automatic t_ee_write();
        logic a;
        int a0 = n_eea, d0 = n_eed, s0 = n_stop;
        m_start();
        m_wbyte(adr(4'b1010, 1'b0), a); chk(a, "R2 ee addr ack", a, 1);
        m_wbyte(8'h40, a);
        m_wbyte(8'h11, a);
        m_wbyte(8'h22, a); chk(a, "R6 data ack", a, 1);
        chk(n_eea == a0 + 1 && last_eea == 8'h40, "R6 addr strobe", last_eea, 8'h40);
        chk(n_eed == d0 + 2 && last_eed == 8'h22, "R6 data strobes", n_eed - d0, 2);
        m_stop();
        repeat (10) @(negedge clk);
        chk(n_stop == s0 + 1, "R6 bus_stop", n_stop - s0, 1);
    endtask

    task automatic t_ee_busy();
        logic a;
        ee_busy = 1'b1;
        m_start();
        m_wbyte(adr(4'b1010, 1'b1), a); chk(!a, "R6 busy nack", a, 0);
        m_stop();
        ee_busy = 1'b0;
    endtask

    task automatic t_ee_read();
        logic a, s; logic [7:0] d;
        logic [7:0] b0 = rd_base + 8'(n_rd);
        int r0 = n_rd;
        m_start();
        m_wbyte(adr(4'b1010, 1'b1), a);
        m_rbyte(1'b1, d); chk(d == b0, "R7 byte0", d, b0);
        m_rbyte(1'b1, d); chk(d == b0 + 8'd1, "R7 byte1", d, b0 + 8'd1);
        m_rbyte(1'b0, d); chk(d == b0 + 8'd2, "R10 byte2 no timeout", d, b0 + 8'd2);
        chk(n_rd == r0 + 3, "R7 advance count", n_rd - r0, 3);
        m_bit(1'b1, s); chk(s == 1'b1, "R7 silent after nack", s, 1);
        m_stop();
    endtask

    task automatic t_flag_read();
        logic a;
        pf_set = 1'b1;
        m_start(); m_wbyte(adr(4'b0110, 1'b1), a); chk(!a, "R8 set gives nack", a, 0); m_stop();
        pf_set = 1'b0;
        m_start(); m_wbyte(adr(4'b0110, 1'b1), a); chk(a, "R8 clear gives ack", a, 1);
        chk(sda_oe == 1'b0, "R8 no data", sda_oe, 0);
        m_stop();
    endtask

    task automatic t_flag_write();
        logic a;
        int p0 = n_pf;
        m_start();
        m_wbyte(adr(4'b0110, 1'b0), a); chk(a, "R9 addr ack", a, 1);
        m_wbyte(8'h9C, a);              chk(a, "R9 dummy addr ack", a, 1);
        m_wbyte(8'h3E, a);              chk(a, "R9 dummy data ack", a, 1);
        chk(n_pf == p0 + 1, "R9 pf_wr once", n_pf - p0, 1);
        m_wbyte(8'h00, a);              chk(!a, "R9 extra nack", a, 0);
        m_stop();
    endtask

    task automatic t_strap_miss();
        logic a;
        int a0 = n_eea, d0 = n_eed;
        m_start();
        m_wbyte({4'b1010, STRAP ^ 3'b001, 1'b0}, a); chk(!a, "R2 strap mismatch nack", a, 0);
        m_wbyte(8'h12, a); chk(!a, "R2 ignored byte nack", a, 0);
        chk(n_eea == a0 && n_eed == d0, "R2 no strobes", n_eea + n_eed, a0 + d0);
        m_stop();
    endtask

    task automatic t_mid_start();
        logic a, s; logic [7:0] d;
        m_start();
        m_bit(1'b1, s); m_bit(1'b0, s); m_bit(1'b1, s); m_bit(1'b1, s);
        m_start();
        m_wbyte(adr(4'b0011, 1'b1), a); chk(a, "R11 restart ack", a, 1);
        m_rbyte(1'b0, d); chk(d == 8'hA2, "R11 read after restart", d, 8'hA2);
        m_stop();
    endtask

    task automatic t_timeout();
        logic s; logic [7:0] b;
        b = adr(4'b0011, 1'b0);
        m_start();
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        sda_m = 1'b1;
        repeat (200) @(negedge clk);
        chk(sda_oe == 1'b1, "R10 ack held before limit", sda_oe, 1);
        repeat (120) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 released after limit", sda_oe, 0);
        m_stop();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_ts_write();
        t_ts_read();
        t_ts_selective();
        t_ee_write();
        t_ee_busy();
        t_ee_read();
        t_flag_read();
        t_flag_write();
        t_strap_miss();
        t_mid_start();
        t_timeout();
        chk(v12 == 0, "R12 drive only while SCL low", v12, 0);
        chk(v13 == 0, "R13 strobes exclusive", v13, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule